// File: doc/BRIEF.md
# Peripheral Request Router

This block sits between a set of peripheral request lines and a bank of DMA channels. Each request line has its own routing register. The register holds a valid flag and a target channel number. While the flag is set, the line drives the request level of its channel. Several lines may share one channel, and the channel level is then the OR of those lines. The block does not transfer data or store channel status. It turns activity on the routed lines into per-channel status events for the channel logic downstream:

- a set pulse for the request-after-stop status,
- a clear pulse for the same status,
- a set pulse for the end-of-receive status.

Software reaches the routing registers through a simple register port. A write takes effect in the cycle of the strobe. A read is answered one cycle later together with a valid pulse. A small access state machine has two states. BUS_IDLE accepts a read, and the transition is to BUS_RESP when `bus_rd` is high. BUS_RESP presents the data and always goes back to BUS_IDLE. Request inputs are treated as synchronous to `clk`. Every channel output follows a change on a request input two clock edges later. The first edge samples the inputs and the second registers the channel outputs.

Top module: `dreq_router`

## Requirements
- R1: After reset, every routing register reads 0, `ch_req`, `ch_ras_set`, `ch_ras_clr`, `ch_eor_set` and `bus_err` are 0, and `bus_rvalid` is 0.
- R2: Routing register i is at byte offset 0x100+4*i for i<64 and 0x1100+4*(i-64) for 64<=i<NUM_REQ. It is 8 bits wide: bit 7 is the valid flag and bits 4:0 the channel. Bits 6:5 are stored and read back but have no routing effect. A read accepted in BUS_IDLE returns the register in `bus_rdata` with `bus_rvalid` high on the next cycle, for exactly one cycle. A read strobe seen in BUS_RESP is not accepted.
- R3: Offsets 0xE0, 0xE4 and 0xE8 read as 0, and writes to them change no routing register and raise no error. Any other offset outside the routing registers behaves the same way.
- R4: A write with bit 7 set and bits 4:0 >= NUM_CH to a routing register is not stored. It raises `bus_err` for one cycle, in the cycle after the write. Any other routing write leaves `bus_err` low.
- R5: A request line whose register has bit 7 clear has no effect on any channel output.
- R6: `ch_req[c]` is the OR of all request lines whose register is valid and names channel c, delayed by two clock edges.
- R7: When `ch_req[c]` goes from 0 to 1, `ch_ras_set[c]` is high for exactly that cycle.
- R8: When `ch_req[c]` goes from 1 to 0, `ch_eor_set[c]` is high for exactly that cycle.
- R9: When any valid line routed to channel c toggles and `ch_req[c]` does not rise, `ch_ras_clr[c]` pulses in the same cycle that a rise would have shown. It is never high together with `ch_ras_set[c]`.
- R10: Rewriting a routing register while its line is high moves the level between channels. The old channel falls (R8) and the new one rises (R7) one edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response pulse |
| bus_err | output | 1 | Rejected routing write pulse |
| req_in | input | NUM_REQ | Peripheral request levels |
| ch_req | output | NUM_CH | Per-channel request level |
| ch_ras_set | output | NUM_CH | Set pulse for request-after-stop status |
| ch_ras_clr | output | NUM_CH | Clear pulse for request-after-stop status |
| ch_eor_set | output | NUM_CH | Set pulse for end-of-receive status |

## Verification
The bench builds the block with the full 75 request lines and only 6 channels. With 6 channels, channel numbers 6 to 31 become illegal, so every rejected-write code can be swept. The small channel count also makes many lines share a channel, which exercises the OR merge and the clear pulses on every channel. Both address windows are swept register by register. Single-line rise and fall sweeps over all 75 lines and a long pseudo-random sequence are compared with a per-cycle model kept in the bench.

// File: rtl/dreq_router_pkg.sv
package dreq_router_pkg;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;

    localparam int MAP_W        = 8;
    localparam int CH_W         = 5;
    localparam int VLD_BIT      = 7;
    localparam int LO_WINDOW    = 64;
    localparam int LO_BASE      = 'h100;
    localparam int HI_BASE      = 'h1100;

endpackage

// File: rtl/dreq_router_map.sv
module dreq_router_map
    import dreq_router_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 32,
    parameter int ADDR_W  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [MAP_W-1:0]               bus_wdata,
    output logic [MAP_W-1:0]               bus_rdata,
    output logic                           bus_rvalid,
    output logic                           bus_err,
    output logic [NUM_REQ-1:0]             map_vld,
    output logic [NUM_REQ-1:0][CH_W-1:0]   map_ch
);

    localparam int IDX_W    = $clog2(NUM_REQ);
    localparam int LO_N     = (NUM_REQ < LO_WINDOW) ? NUM_REQ : LO_WINDOW;
    localparam int HI_N     = (NUM_REQ > LO_WINDOW) ? NUM_REQ - LO_WINDOW : 0;
    localparam logic [31:0] LO_END = 32'(LO_BASE + 4 * LO_N);
    localparam logic [31:0] HI_END = 32'(HI_BASE + 4 * HI_N);

    logic [NUM_REQ-1:0][MAP_W-1:0] map_q;
    logic [31:0]      a32;
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             bad_ch;
    logic             wr_ok;
    logic [MAP_W-1:0] rd_word;
    bus_state_e       state_q, state_d;
    logic [MAP_W-1:0] rdata_q;
    logic             err_q;

    assign a32 = 32'(bus_addr);

    // address decode into a routing register index
    always_comb begin
        hit = 1'b0;
        idx = '0;
        if (a32[1:0] == 2'b00) begin
            if (a32 >= 32'(LO_BASE) && a32 < LO_END) begin
                hit = 1'b1;
                idx = IDX_W'((a32 - 32'(LO_BASE)) >> 2);
            end else if (HI_N > 0 && a32 >= 32'(HI_BASE) && a32 < HI_END) begin
                hit = 1'b1;
                idx = IDX_W'(((a32 - 32'(HI_BASE)) >> 2) + 32'(LO_WINDOW));
            end
        end
    end

    assign bad_ch  = bus_wdata[VLD_BIT] && (32'(bus_wdata[CH_W-1:0]) >= 32'(NUM_CH));
    assign wr_ok   = bus_wr && hit && !bad_ch;
    assign rd_word = hit ? map_q[idx] : '0;

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_map
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                map_q[r] <= '0;
            end else if (wr_ok && idx == IDX_W'(r)) begin
                map_q[r] <= bus_wdata;
            end
        end
        assign map_vld[r] = map_q[r][VLD_BIT];
        assign map_ch[r]  = map_q[r][CH_W-1:0];
    end

    // access state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = bus_rd ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // access state machine: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (state_q == BUS_IDLE && bus_rd) rdata_q <= rd_word;
            err_q <= bus_wr && hit && bad_ch;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = (state_q == BUS_RESP);
    assign bus_err    = err_q;

endmodule

// File: rtl/dreq_router_merge.sv
module dreq_router_merge
    import dreq_router_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_REQ-1:0]            req_in,
    input  logic [NUM_REQ-1:0]            map_vld,
    input  logic [NUM_REQ-1:0][CH_W-1:0]  map_ch,
    output logic [NUM_CH-1:0]             lvl,
    output logic [NUM_CH-1:0]             upd
);

    logic [NUM_REQ-1:0] req_s;
    logic [NUM_REQ-1:0] req_p;
    logic [NUM_REQ-1:0] tog;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_s <= '0;
            req_p <= '0;
        end else begin
            req_s <= req_in;
            req_p <= req_s;
        end
    end

    assign tog = req_s ^ req_p;

    always_comb begin
        lvl = '0;
        upd = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int r = 0; r < NUM_REQ; r++) begin
                if (map_vld[r] && map_ch[r] == CH_W'(c)) begin
                    lvl[c] = lvl[c] | req_s[r];
                    upd[c] = upd[c] | tog[r];
                end
            end
        end
    end

endmodule

// File: rtl/dreq_router_events.sv
module dreq_router_events #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] lvl,
    input  logic [NUM_CH-1:0] upd,
    output logic [NUM_CH-1:0] ch_req,
    output logic [NUM_CH-1:0] ch_ras_set,
    output logic [NUM_CH-1:0] ch_ras_clr,
    output logic [NUM_CH-1:0] ch_eor_set
);

    logic [NUM_CH-1:0] lvl_q;
    logic [NUM_CH-1:0] rise;

    assign rise = lvl & ~lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q      <= '0;
            ch_ras_set <= '0;
            ch_ras_clr <= '0;
            ch_eor_set <= '0;
        end else begin
            lvl_q      <= lvl;
            ch_ras_set <= rise;
            ch_ras_clr <= upd & ~rise;
            ch_eor_set <= ~lvl & lvl_q;
        end
    end

    assign ch_req = lvl_q;

endmodule

// File: rtl/dreq_router.sv
module dreq_router
    import dreq_router_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 32,
    parameter int ADDR_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    output logic                bus_rvalid,
    output logic                bus_err,
    input  logic [NUM_REQ-1:0]  req_in,
    output logic [NUM_CH-1:0]   ch_req,
    output logic [NUM_CH-1:0]   ch_ras_set,
    output logic [NUM_CH-1:0]   ch_ras_clr,
    output logic [NUM_CH-1:0]   ch_eor_set
);

    logic [NUM_REQ-1:0]           map_vld;
    logic [NUM_REQ-1:0][CH_W-1:0] map_ch;
    logic [NUM_CH-1:0]            lvl;
    logic [NUM_CH-1:0]            upd;

    dreq_router_map #(
        .NUM_REQ (NUM_REQ),
        .NUM_CH  (NUM_CH),
        .ADDR_W  (ADDR_W)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .bus_err    (bus_err),
        .map_vld    (map_vld),
        .map_ch     (map_ch)
    );

    dreq_router_merge #(
        .NUM_REQ (NUM_REQ),
        .NUM_CH  (NUM_CH)
    ) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_in  (req_in),
        .map_vld (map_vld),
        .map_ch  (map_ch),
        .lvl     (lvl),
        .upd     (upd)
    );

    dreq_router_events #(
        .NUM_CH (NUM_CH)
    ) u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (lvl),
        .upd        (upd),
        .ch_req     (ch_req),
        .ch_ras_set (ch_ras_set),
        .ch_ras_clr (ch_ras_clr),
        .ch_eor_set (ch_eor_set)
    );

endmodule

// File: rtl/dreq_router_chk.sv
module dreq_router_chk #(
    parameter int NUM_CH = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [11:0]       rd_page,
    input logic              wd_vld,
    input logic [4:0]        wd_ch,
    input logic [7:0]        bus_rdata,
    input logic              bus_rvalid,
    input logic              bus_err,
    input logic [NUM_CH-1:0] ch_req,
    input logic [NUM_CH-1:0] ch_ras_set,
    input logic [NUM_CH-1:0] ch_ras_clr,
    input logic [NUM_CH-1:0] ch_eor_set
);

    AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !bus_rvalid); // R2

    AST_STATUS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && $past(bus_rd) && $past(rd_page) == 12'h00E) |-> bus_rdata == 8'h00); // R3

    AST_ERR_NEEDS_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> ($past(bus_wr) && $past(wd_vld) && (32'($past(wd_ch)) >= 32'(NUM_CH)))); // R4

    AST_LEVEL_CHANGE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_req ^ $past(ch_req)) == (ch_ras_set | ch_eor_set)); // R6

    AST_RAS_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_ras_set & ~ch_req) == '0); // R7

    AST_EOR_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_eor_set & ch_req) == '0); // R8

    AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_ras_set & ch_ras_clr) == '0); // R9

endmodule

bind dreq_router dreq_router_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .rd_page    (bus_addr[15:4]),
    .wd_vld     (bus_wdata[7]),
    .wd_ch      (bus_wdata[4:0]),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .bus_err    (bus_err),
    .ch_req     (ch_req),
    .ch_ras_set (ch_ras_set),
    .ch_ras_clr (ch_ras_clr),
    .ch_eor_set (ch_eor_set)
);

// File: tb/dreq_router_tb.sv
`timescale 1ns/1ps
module dreq_router_tb;

    localparam int NR = 75;
    localparam int NC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          bus_rvalid;
    logic          bus_err;
    logic [NR-1:0] req_in = '0;
    logic [NC-1:0] ch_req, ch_ras_set, ch_ras_clr, ch_eor_set;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0]    m_reg [NR];
    logic [NC-1:0] prev_lvl = '0;
    logic [NR-1:0] prev_req = '0;

    always #2.5 clk = ~clk;

    dreq_router #(.NUM_REQ(NR), .NUM_CH(NC), .ADDR_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .bus_err(bus_err), .req_in(req_in),
        .ch_req(ch_req), .ch_ras_set(ch_ras_set), .ch_ras_clr(ch_ras_clr),
        .ch_eor_set(ch_eor_set)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] addr_of(input int i);
        if (i < 64) return 16'(32'h100 + 4 * i);
        return 16'(32'h1100 + 4 * (i - 64));
    endfunction

    task automatic reg_write(input logic [15:0] a, input logic [7:0] d, input bit exp_err, input string rq);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        chk(bus_err == exp_err, rq, 32'(bus_err), 32'(exp_err));
    endtask

    task automatic reg_read(input logic [15:0] a, input logic [7:0] exp, input string rq);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        chk(bus_rvalid == 1'b1 && bus_rdata == exp, rq, {23'b0, bus_rvalid, bus_rdata}, {23'b0, 1'b1, exp});
        @(posedge clk);
    endtask

    // one observation step: optional routing write, new request vector, compare after two edges
    task automatic step(input logic [NR-1:0] r, input bit do_wr, input int wi, input logic [7:0] wv, input string rq);
        logic [NC-1:0] lv, up, e_ras, e_clr, e_eor;
        @(negedge clk);
        req_in = r;
        if (do_wr) begin
            bus_addr = addr_of(wi); bus_wdata = wv; bus_wr = 1'b1;
            m_reg[wi] = wv;
        end
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        @(posedge clk);
        @(negedge clk);
        lv = '0; up = '0;
        for (int i = 0; i < NR; i++) begin
            if (m_reg[i][7] && int'(m_reg[i][4:0]) < NC) begin
                if (r[i]) lv[m_reg[i][4:0]] = 1'b1;
                if (r[i] != prev_req[i]) up[m_reg[i][4:0]] = 1'b1;
            end
        end
        e_ras = lv & ~prev_lvl;
        e_eor = ~lv & prev_lvl;
        e_clr = up & ~e_ras;
        chk(ch_req == lv, {rq, " level R6"}, 32'(ch_req), 32'(lv));
        chk(ch_ras_set == e_ras, {rq, " rise R7"}, 32'(ch_ras_set), 32'(e_ras));
        chk(ch_eor_set == e_eor, {rq, " fall R8"}, 32'(ch_eor_set), 32'(e_eor));
        chk(ch_ras_clr == e_clr, {rq, " clear R9"}, 32'(ch_ras_clr), 32'(e_clr));
        prev_lvl = lv;
        prev_req = r;
    endtask

    function automatic logic [7:0] init_val(input int i);
        return {(i % 3 != 0), 2'b11, 5'(i % NC)};
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [95:0] lf;
        logic [NR-1:0] v;
        for (int i = 0; i < NR; i++) m_reg[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(ch_req == '0 && ch_ras_set == '0 && ch_ras_clr == '0 && ch_eor_set == '0,
            "R1 channel outputs", 32'({ch_req, ch_ras_set, ch_ras_clr, ch_eor_set}), 0);
        chk(bus_rvalid == 1'b0 && bus_err == 1'b0, "R1 bus outputs", 32'({bus_rvalid, bus_err}), 0);
        reg_read(addr_of(0), 8'h00, "R1 reg0");
        reg_read(addr_of(NR - 1), 8'h00, "R1 reg74");

        // R2: write then read every routing register in both windows
        for (int i = 0; i < NR; i++) begin
            reg_write(addr_of(i), init_val(i), 1'b0, "R4 legal write no err");
            m_reg[i] = init_val(i);
        end
        for (int i = 0; i < NR; i++) reg_read(addr_of(i), init_val(i), "R2 readback");

        // R2: read strobe held during the response is not accepted
        @(negedge clk);
        bus_addr = addr_of(3); bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(bus_rvalid == 1'b1, "R2 first response", 32'(bus_rvalid), 1);
        @(posedge clk); @(negedge clk);
        chk(bus_rvalid == 1'b0, "R2 no back-to-back accept", 32'(bus_rvalid), 0);
        bus_rd = 1'b0;
        @(posedge clk);

        // R4: every illegal channel code is rejected
        for (int c = NC; c < 32; c++) begin
            reg_write(addr_of(10), 8'h80 | 8'(c), 1'b1, "R4 bad channel err");
            reg_read(addr_of(10), init_val(10), "R4 not stored");
        end
        reg_write(addr_of(70), 8'h1F, 1'b0, "R4 invalid entry no err");
        reg_read(addr_of(70), 8'h1F, "R4 invalid entry stored");
        reg_write(addr_of(70), init_val(70), 1'b0, "R4 restore");

        // R3: status and unmapped offsets
        reg_write(16'h00E0, 8'hFF, 1'b0, "R3 write E0");
        reg_write(16'h00E4, 8'h81, 1'b0, "R3 write E4");
        reg_write(16'h00E8, 8'h82, 1'b0, "R3 write E8");
        reg_read(16'h00E0, 8'h00, "R3 read E0");
        reg_read(16'h00E4, 8'h00, "R3 read E4");
        reg_read(16'h00E8, 8'h00, "R3 read E8");
        reg_read(16'h0101, 8'h00, "R3 misaligned");
        reg_read(addr_of(NR - 1) + 16'd4, 8'h00, "R3 past end");
        reg_read(addr_of(0), init_val(0), "R3 reg0 untouched");
        reg_read(addr_of(64), init_val(64), "R3 reg64 untouched");

        // R5..R9: each line alone rises then falls (lines with i%3==0 are unrouted)
        for (int i = 0; i < NR; i++) begin
            v = '0; v[i] = 1'b1;
            step(v, 1'b0, 0, 8'h00, (i % 3 == 0) ? "R5 unrouted line up" : "single line up");
            step('0, 1'b0, 0, 8'h00, (i % 3 == 0) ? "R5 unrouted line down" : "single line down");
        end

        // R6/R9: two lines sharing channel 1
        v = '0; v[1] = 1'b1;  step(v, 1'b0, 0, 8'h00, "R6 share a");
        v[7] = 1'b1;          step(v, 1'b0, 0, 8'h00, "R9 share b up");
        v[1] = 1'b0;          step(v, 1'b0, 0, 8'h00, "R9 share a down");
        v[7] = 1'b0;          step(v, 1'b0, 0, 8'h00, "R8 share b down");

        // R10: remap a high line to another channel, then to unrouted, then back
        v = '0; v[2] = 1'b1;  step(v, 1'b0, 0, 8'h00, "R10 setup");
        step(v, 1'b1, 2, 8'h84, "R10 move to ch4");
        step(v, 1'b1, 2, 8'h04, "R10 invalidate");
        step(v, 1'b1, 2, 8'h82, "R10 restore");
        step('0, 1'b0, 0, 8'h00, "R10 drop");

        // pseudo-random patterns over all lines
        lf = 96'h1234_5678_9ABC_DEF0_0F1E_2D3C;
        for (int k = 0; k < 400; k++) begin
            for (int s = 0; s < 11; s++) lf = {lf[94:0], lf[95] ^ lf[93] ^ lf[48] ^ lf[46]};
            step(lf[NR-1:0], 1'b0, 0, 8'h00, "random");
        end
        step('0, 1'b0, 0, 8'h00, "random drain");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule